// File: doc/BRIEF.md
# Scatter-Gather Page Address Translator

This block feeds a bus-master engine with the physical address of every quadword it moves, when the buffer behind the transfer is spread over separate 4 KB pages of system memory. Software programs one 32-bit start word and pulses a start strobe. In scatter/gather mode, the upper twenty bits of that word locate a 4 KB-aligned table of page descriptors, and the lower twelve bits give the byte offset at which the transfer begins inside the first data page.

The block reads one 32-bit descriptor at a time through a simple request/response memory read port. It then emits one physical address per quadword on a valid/ready stream. Each address joins the page base taken from the descriptor with the running in-page offset. When the offset runs off the end of a page, the block fetches the next descriptor before it emits anything more. A descriptor whose lowest bit is set marks the last page. Once that page has been used up, the block pulses done. From then on it answers any further demand with a sticky overrun flag and emits no address.

With scatter/gather turned off, the start word is a plain linear address and the block only counts upward through it.

Top module: `sg_page_xlate`

## Requirements
- R1: While reset is held, addrValid, memReqValid, donePulse and overrun are all low.
- R2: In scatter/gather mode, descriptor number k (counting from 0 after each start) is read at address {startAddr[31:12], k[9:0], 2'b00}. Bits 31:12 of the read address never change during a run.
- R3: In scatter/gather mode, physAddr = {descriptor[31:12], offset[11:0]}. Descriptor bits 11:1 are ignored. The first page begins at offset {startAddr[11:3], 3'b000}, and every later page begins at offset 0, so physAddr[2:0] is always 0.
- R4: The offset advances by 8 on each cycle where addrValid and addrReady are both high. While addrValid is high and addrReady is low, addrValid and physAddr stay unchanged.
- R5: After the beat at offset 0xFF8 of a page that is not the last page is accepted, addrValid stays low and the next descriptor is requested. Addresses resume once its response arrives. memReqValid and addrValid are never high together.
- R6: Descriptor bit 0 is the end-of-table flag. On the cycle after the beat at offset 0xFF8 of a flagged page is accepted, donePulse is high for exactly one cycle. After that, no further address is emitted and no further descriptor is read.
- R7: If addrReady is high while the block is finished, overrun rises on the next cycle and stays high until the next start. addrValid stays low while overrun is high.
- R8: When sgEnable is low at start, no descriptor is read, and the n-th emitted address (counting from 0) is {startAddr[31:3], 3'b000} + 8*n, carrying freely across page boundaries.
- R9: Once raised, memReqValid stays high with the same memReqAddr until memReqReady is seen high. A memRspValid that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Loads the start word and begins a new run |
| sgEnable | input | 1 | Sampled at start: 1 selects scatter/gather mode, 0 selects linear mode |
| startAddr | input | 32 | Table base and first-page offset, or the linear start address |
| addrReady | input | 1 | Consumer takes the current address or demands the next one |
| addrValid | output | 1 | physAddr is valid |
| physAddr | output | 32 | Physical address of the current quadword |
| memReqValid | output | 1 | Descriptor read request |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Descriptor read address |
| memRspValid | input | 1 | Read data is valid |
| memRspData | input | 32 | Descriptor word |
| donePulse | output | 1 | One-cycle pulse when the flagged last page is used up |
| overrun | output | 1 | Sticky flag: data was demanded after the end of the table |

## Verification
The embedded assertions check the cycle-local rules on every clock:
- a stalled address holds steady;
- a pending descriptor read holds its request;
- done lasts a single cycle;
- overrun is sticky and silences the address stream;
- a non-final page wrap drops valid and raises a read;
- every address is quadword aligned.

Only the bench's scenarios can show the arithmetic across a whole run. That covers the exact fetch address sequence, the page base joined with the right first-page offset, and done landing on the last beat of the flagged page and nowhere else. It also covers linear mode carrying across a 4 KB line and reading nothing.

// File: rtl/sgx_pkg.sv
package sgx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_REQ,
    ST_FETCH_WAIT,
    ST_STREAM,
    ST_END,
    ST_LINEAR
  } sgxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;   // capture start word, clear index and flags
    logic fetchIssued; // descriptor request accepted: bump index
    logic capDesc;     // descriptor response: latch page base and end flag
    logic advance;     // beat accepted: step offset by one quadword
    logic markOvr;     // demand after end of table
    logic selLinear;   // present the linear address
  } sgxStrobe_t;

endpackage

// File: rtl/sgx_dpath.sv
module sgx_dpath
  import sgx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BEAT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sgxStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              atPageEnd,
  output logic              eotFlag,
  output logic              ovrFlag
);

  localparam int OFF_W      = PAGE_SHIFT;
  localparam int BASE_W     = ADDR_W - PAGE_SHIFT;
  localparam int IDX_W      = PAGE_SHIFT - 2;
  localparam int BEAT_BYTES = 1 << BEAT_SHIFT;
  localparam logic [OFF_W-1:0] PAGE_LAST = OFF_W'((1 << PAGE_SHIFT) - BEAT_BYTES);

  logic [BASE_W-1:0] tblBase;
  logic [IDX_W-1:0]  descIdx;
  logic [BASE_W-1:0] pageBase;
  logic [OFF_W-1:0]  pageOff;
  logic [ADDR_W-1:0] linAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBase  <= '0;
      descIdx  <= '0;
      pageBase <= '0;
      pageOff  <= '0;
      linAddr  <= '0;
      eotFlag  <= 1'b0;
      ovrFlag  <= 1'b0;
    end else if (strobe.loadStart) begin
      tblBase  <= startAddr[ADDR_W-1:PAGE_SHIFT];
      descIdx  <= '0;
      pageOff  <= {startAddr[PAGE_SHIFT-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}};
      linAddr  <= {startAddr[ADDR_W-1:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}};
      eotFlag  <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      // index stays inside one table page: no carry into the base
      if (strobe.fetchIssued) descIdx <= descIdx + IDX_W'(1);
      if (strobe.capDesc) begin
        pageBase <= memRspData[ADDR_W-1:PAGE_SHIFT];
        eotFlag  <= memRspData[0];
      end
      if (strobe.advance) begin
        pageOff <= pageOff + OFF_W'(BEAT_BYTES);
        linAddr <= linAddr + ADDR_W'(BEAT_BYTES);
      end
      if (strobe.markOvr) ovrFlag <= 1'b1;
    end
  end

  assign memReqAddr = {tblBase, descIdx, 2'b00};
  assign physAddr   = strobe.selLinear ? linAddr : {pageBase, pageOff};
  assign atPageEnd  = (pageOff == PAGE_LAST);

  // R3: every emitted address is quadword aligned
  a_r3_beat_aligned: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[BEAT_SHIFT-1:0] == '0);

  // R7: overrun holds until a new start
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovrFlag && !strobe.loadStart |=> ovrFlag);

  // R2: table base is frozen between starts
  a_r2_base_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStart |=> $stable(memReqAddr[ADDR_W-1:PAGE_SHIFT]));

endmodule

// File: rtl/sgx_ctrl.sv
module sgx_ctrl
  import sgx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       sgEnable,
  input  logic       addrReady,
  input  logic       memReqReady,
  input  logic       memRspValid,
  input  logic       atPageEnd,
  input  logic       eotFlag,
  output sgxStrobe_t strobe,
  output logic       addrValid,
  output logic       memReqValid,
  output logic       donePulse
);

  sgxState_e state, stateNext;
  logic      fireDone;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    addrValid   = 1'b0;
    memReqValid = 1'b0;
    fireDone    = 1'b0;
    strobe.selLinear = (state == ST_LINEAR);
    unique case (state)
      ST_IDLE: ;
      ST_FETCH_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) begin
          strobe.fetchIssued = 1'b1;
          stateNext          = ST_FETCH_WAIT;
        end
      end
      ST_FETCH_WAIT: begin
        if (memRspValid) begin
          strobe.capDesc = 1'b1;
          stateNext      = ST_STREAM;
        end
      end
      ST_STREAM: begin
        addrValid = 1'b1;
        if (addrReady) begin
          strobe.advance = 1'b1;
          if (atPageEnd) begin
            fireDone  = eotFlag;
            stateNext = eotFlag ? ST_END : ST_FETCH_REQ;
          end
        end
      end
      ST_END: begin
        if (addrReady) strobe.markOvr = 1'b1;
      end
      ST_LINEAR: begin
        addrValid = 1'b1;
        if (addrReady) strobe.advance = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (startPulse) begin
      strobe.loadStart   = 1'b1;
      strobe.fetchIssued = 1'b0;
      strobe.capDesc     = 1'b0;
      strobe.advance     = 1'b0;
      strobe.markOvr     = 1'b0;
      fireDone           = 1'b0;
      stateNext          = sgEnable ? ST_FETCH_REQ : ST_LINEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNext;
      donePulse <= fireDone;
    end
  end

  // R9: a pending descriptor read is held until taken
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady && !startPulse |=> memReqValid);

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R5: wrap of a non-final page stops addresses and starts a fetch
  a_r5_wrap_fetch: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_STREAM && addrReady && atPageEnd && !eotFlag && !startPulse
    |=> !addrValid && memReqValid);

endmodule

// File: rtl/sg_page_xlate.sv
module sg_page_xlate
  import sgx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int BEAT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              sgEnable,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              addrReady,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              donePulse,
  output logic              overrun
);

  sgxStrobe_t strobe;
  logic       atPageEnd;
  logic       eotFlag;

  sgx_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .sgEnable    (sgEnable),
    .addrReady   (addrReady),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .atPageEnd   (atPageEnd),
    .eotFlag     (eotFlag),
    .strobe      (strobe),
    .addrValid   (addrValid),
    .memReqValid (memReqValid),
    .donePulse   (donePulse)
  );

  sgx_dpath #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BEAT_SHIFT (BEAT_SHIFT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .startAddr  (startAddr),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .physAddr   (physAddr),
    .atPageEnd  (atPageEnd),
    .eotFlag    (eotFlag),
    .ovrFlag    (overrun)
  );

  // R4: a stalled address holds steady
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    addrValid && !addrReady && !startPulse |=> addrValid && $stable(physAddr));

  // R7: no address while overrun is flagged
  a_r7_ovr_silent: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !startPulse |-> !addrValid);

  // R5: fetch and address stream never overlap
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && addrValid));

endmodule

// File: tb/sg_page_xlate_bench.sv
module sg_page_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        sgEnable = 1'b0;
  logic [31:0] startAddr = '0;
  logic        addrReady = 1'b0;
  logic        addrValid;
  logic [31:0] physAddr;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = 32'hDEAD_BEEF;
  logic        donePulse;
  logic        overrun;

  always #4 clk = ~clk; // 125 MHz

  sg_page_xlate u_sg_page_xlate (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .sgEnable(sgEnable),
    .startAddr(startAddr), .addrReady(addrReady), .addrValid(addrValid),
    .physAddr(physAddr), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .donePulse(donePulse), .overrun(overrun)
  );

  // reference state
  int unsigned memTbl [int unsigned];
  logic [31:0] expAddrQ [$];
  logic [31:0] expFetchQ [$];
  int          vecs = 0;
  int          miss = 0;
  int          phase = 0;  // 0 idle, 1 sg running, 2 finished, 3 linear
  bit          expDone = 0;
  bit          expOvr = 0;
  int          cyc = 0;
  int          rspCnt = 0;
  logic [31:0] rspWord = '0;
  int          readyMode = 0; // 0 low, 1 pattern, 2 high
  int          negCnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory and consumer drivers, at the falling edge
  always @(negedge clk) begin
    negCnt++;
    memReqReady = (negCnt % 3) != 0;
    addrReady   = (readyMode == 2) ? 1'b1 :
                  (readyMode == 1) ? ((negCnt % 5) != 2) : 1'b0;
    memRspValid = 1'b0;
    memRspData  = 32'hDEAD_BEEF;
    if (rspCnt > 0) begin
      rspCnt--;
      if (rspCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rspWord;
      end
    end
  end

  // cycle-by-cycle compare, just before each rising edge
  always begin
    bit nextDone;
    logic [31:0] e;
    @(negedge clk);
    #3;
    if (rstN) begin
      cyc++;
      nextDone = 0;
      chk("R6 done pulse", {31'b0, donePulse}, {31'b0, expDone});
      chk("R7 overrun flag", {31'b0, overrun}, {31'b0, expOvr});
      if (memReqValid && addrValid) chk("R5 fetch and stream overlap", 1, 0);
      if (startPulse) begin
        phase  = sgEnable ? 1 : 3;
        expOvr = 0;
      end else begin
        if (phase == 2) begin
          chk("R6 no address after end", {31'b0, addrValid}, 0);
          if (addrReady) expOvr = 1;
        end
        if (addrValid && addrReady) begin
          if (expAddrQ.size() == 0) chk("R3 unexpected beat", 1, 0);
          else begin
            e = expAddrQ.pop_front();
            if (phase == 3) chk("R8 linear address", physAddr, e);
            else chk("R3 R4 physical address", physAddr, e);
            if (phase == 1 && expAddrQ.size() == 0) begin
              nextDone = 1;
              phase    = 2;
            end
          end
        end
      end
      if (memReqValid && memReqReady) begin
        if (expFetchQ.size() == 0) chk("R6 R8 unexpected descriptor read", 1, 0);
        else chk("R2 descriptor read address", memReqAddr, expFetchQ.pop_front());
        rspCnt  = 3;
        rspWord = memTbl.exists(memReqAddr) ? memTbl[memReqAddr] : 32'h0;
      end
      expDone = nextDone;
      if (cyc > 150000) begin
        miss++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
      end
    end
  end

  task automatic addPage(input logic [31:0] tblStart, input int idx,
                         input logic [31:0] word, input int firstOff);
    logic [31:0] a;
    a = {tblStart[31:12], idx[9:0], 2'b00};
    memTbl[a] = word;
    expFetchQ.push_back(a);
    for (int off = firstOff; off < 4096; off += 8)
      expAddrQ.push_back({word[31:12], off[11:0]});
  endtask

  task automatic pulseStart(input logic mode, input logic [31:0] sa);
    @(negedge clk);
    sgEnable   = mode;
    startAddr  = sa;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic waitPhase(input int p);
    for (int i = 0; i < 20000 && phase != p; i++) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #3;
    // R1: reset state
    chk("R1 addrValid in reset", {31'b0, addrValid}, 0);
    chk("R1 memReqValid in reset", {31'b0, memReqValid}, 0);
    chk("R1 donePulse in reset", {31'b0, donePulse}, 0);
    chk("R1 overrun in reset", {31'b0, overrun}, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // three pages, first starting at 0xF80, middle descriptor has junk low bits
    addPage(32'h0003_4F80, 0, 32'h1111_1000, 12'hF80);
    addPage(32'h0003_4F80, 1, 32'h2222_2ABC, 0);
    addPage(32'h0003_4F80, 2, 32'h3333_3001, 0);
    pulseStart(1'b1, 32'h0003_4F80);
    readyMode = 1;
    waitPhase(2);
    readyMode = 0;
    repeat (6) @(negedge clk);
    chk("R6 all descriptors read", expFetchQ.size(), 0);
    chk("R3 all beats issued", expAddrQ.size(), 0);
    readyMode = 2;   // R7: demand past end of table
    repeat (4) @(negedge clk);
    readyMode = 0;
    repeat (5) @(negedge clk);

    // single flagged page, start offset 0xFFD aligns to 0xFF8
    addPage(32'h0007_7FFD, 0, 32'h4444_4FFD, 12'hFF8);
    pulseStart(1'b1, 32'h0007_7FFD);
    readyMode = 2;
    waitPhase(2);
    readyMode = 0;
    repeat (6) @(negedge clk);
    chk("R6 single page read count", expFetchQ.size(), 0);

    // R8: linear mode crossing a 4 KB line
    for (int n = 0; n < 6; n++) expAddrQ.push_back(32'h1234_5FF0 + 32'(8 * n));
    pulseStart(1'b0, 32'h1234_5FF4);
    readyMode = 1;
    for (int i = 0; i < 200 && expAddrQ.size() != 0; i++) @(negedge clk);
    readyMode = 0;
    repeat (8) @(negedge clk);
    chk("R8 linear beats issued", expAddrQ.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule